// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block holds caption byte pairs for standard-definition video and releases them on the caption lines. A host loads one byte pair per field into a one-pair store, one store for the odd field and one for the even field. The video timing side presents a line number, a field flag and a one-cycle line strobe at the start of every line. When the strobe marks a caption line of a field that the active mode enables, the block raises an insert-enable for that line and presents the two caption bytes.

There is only one stage of storage per field, so a pair written before a caption line is emitted on that line, with no extra frame of latency. Each store has a free flag that the host polls before writing. When a caption line arrives with nothing new in the store, a null pair is emitted. The field selection mode is only taken over at the start of a field, so a field is never half-captioned. Waveform generation (clock run-in, bit shaping) is left to the stages downstream.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset, ins_en is 0, both bits of buf_free are 1 and both caption bytes read 0x80.
- R2: A line strobe with line_num 21 and field_odd 1, or with line_num 284 and field_odd 0, is a caption line. If the field is enabled and std_525 is 1, ins_en rises one cycle after that strobe and stays high until one cycle after the next line strobe.
- R3: Mode encoding on cc_mode: 00 no field, 01 odd field only, 10 even field only, 11 both fields (bit 0 enables the odd field, bit 1 the even field).
- R4: A new cc_mode value is taken over only at a field boundary. A field boundary is a line strobe whose field_odd differs from the field_odd of the previous strobe (the first strobe after reset with field_odd 1 is also one). Strobes inside a field keep the mode in use.
- R5: While std_525 is 0, no caption line causes an insertion, and the stored pair and the free flags stay unchanged.
- R6: A write (wr_en 1) loads {wr_byte1, wr_byte2} into the odd store when wr_fld is 1 and into the even store when wr_fld is 0. It clears that store's free flag (buf_free[1] odd, buf_free[0] even) one cycle later.
- R7: An insertion empties the store of its field: its free flag is 1 in the cycle in which ins_en first shows the line.
- R8: If the store of the field is empty on a caption line, the pair 0x80, 0x80 is emitted with ins_en high.
- R9: A write into a store in the same cycle as that store's caption strobe emits the old pair, keeps the new pair and leaves the free flag at 0.
- R10: A pair kept in a store through disabled caption lines is emitted unchanged on the first enabled caption line of its field.
- R11: A strobe on line 21 of the even field, on line 284 of the odd field, or on any other line does not insert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_525 | input | 1 | 1 when the video standard in use has 525-line timing |
| cc_mode | input | 2 | Field selection request, 00 none, 01 odd, 10 even, 11 both |
| line_stb | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | 10 | Number of the line starting with line_stb |
| field_odd | input | 1 | 1 in the odd field, 0 in the even field |
| wr_en | input | 1 | Host write strobe for a byte pair |
| wr_fld | input | 1 | Target store of the write, 1 odd, 0 even |
| wr_byte1 | input | 8 | First caption byte of the pair |
| wr_byte2 | input | 8 | Second caption byte of the pair |
| ins_en | output | 1 | High for the whole caption line being inserted |
| cc_byte1 | output | 8 | First caption byte for the line |
| cc_byte2 | output | 8 | Second caption byte for the line |
| buf_free | output | 2 | Store free flags, bit 1 odd, bit 0 even |

## Verification
The properties assume that line_stb is a single-cycle pulse with line_num and field_odd valid in that same cycle, and that caption lines of the two fields are never on back-to-back strobes. The free-flag property further assumes that a store only becomes free through an insertion and not through a reset in mid-run. The bench drives every strobe as a one-cycle pulse from its line task, steps line numbers the way a real field does (field start, caption line, the line after it), and only changes field_odd on the first strobe of a field.

// File: rtl/cc_ins_pkg.sv
package cc_ins_pkg;

  localparam int CC_BYTE_W = 8;

  typedef enum logic [1:0] {
    CC_NONE = 2'b00,
    CC_ODD  = 2'b01,
    CC_EVEN = 2'b10,
    CC_BOTH = 2'b11
  } cc_mode_e;

  typedef struct packed {
    logic [CC_BYTE_W-1:0] b1;
    logic [CC_BYTE_W-1:0] b2;
  } cc_pair_t;

  localparam logic [CC_BYTE_W-1:0] CC_NULL_BYTE = 8'h80;

  function automatic cc_pair_t cc_null_pair();
    cc_pair_t p;
    p.b1 = CC_NULL_BYTE;
    p.b2 = CC_NULL_BYTE;
    return p;
  endfunction

endpackage

// File: rtl/cc_mode_sync.sv
module cc_mode_sync
  import cc_ins_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_stb,
  input  logic     field_odd,
  input  cc_mode_e mode_req,
  output cc_mode_e mode_eff
);

  logic     last_fld_q, last_fld_d;
  cc_mode_e mode_q, mode_d;
  logic     fld_edge;

  // A strobe opening a field with a different flag marks the boundary
  assign fld_edge = line_stb && (field_odd != last_fld_q);
  assign mode_eff = fld_edge ? mode_req : mode_q;

  always_comb begin
    last_fld_d = last_fld_q;
    mode_d     = mode_q;
    if (line_stb) last_fld_d = field_odd;
    if (fld_edge) mode_d = mode_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_fld_q <= 1'b0;
      mode_q     <= CC_NONE;
    end else begin
      last_fld_q <= last_fld_d;
      mode_q     <= mode_d;
    end
  end

endmodule

// File: rtl/cc_line_match.sv
module cc_line_match
  import cc_ins_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int ODD_LINE  = 21,
  parameter int EVEN_LINE = 284
) (
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic              std_525,
  input  cc_mode_e          mode_eff,
  output logic [1:0]        hit
);

  localparam logic [LINE_W-1:0] ODD_L  = LINE_W'(ODD_LINE);
  localparam logic [LINE_W-1:0] EVEN_L = LINE_W'(EVEN_LINE);

  logic qual;
  logic [1:0] mode_bits;

  assign qual      = line_stb && std_525;
  assign mode_bits = mode_eff;

  // hit[1] odd field caption line, hit[0] even field caption line
  always_comb begin
    hit[1] = qual && field_odd  && (line_num == ODD_L)  && mode_bits[0];
    hit[0] = qual && !field_odd && (line_num == EVEN_L) && mode_bits[1];
  end

endmodule

// File: rtl/cc_field_buf.sv
module cc_field_buf
  import cc_ins_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  cc_pair_t wr_pair,
  input  logic     take,
  output cc_pair_t pair_q,
  output logic     full_q
);

  cc_pair_t pair_d;
  logic     full_d;

  always_comb begin
    pair_d = pair_q;
    full_d = full_q;
    if (wr) begin
      pair_d = wr_pair;
      full_d = 1'b1;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= cc_null_pair();
      full_q <= 1'b0;
    end else begin
      if (wr) pair_q <= pair_d;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
  import cc_ins_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int ODD_LINE  = 21,
  parameter int EVEN_LINE = 284
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 std_525,
  input  logic [1:0]           cc_mode,
  input  logic                 line_stb,
  input  logic [LINE_W-1:0]    line_num,
  input  logic                 field_odd,
  input  logic                 wr_en,
  input  logic                 wr_fld,
  input  logic [CC_BYTE_W-1:0] wr_byte1,
  input  logic [CC_BYTE_W-1:0] wr_byte2,
  output logic                 ins_en,
  output logic [CC_BYTE_W-1:0] cc_byte1,
  output logic [CC_BYTE_W-1:0] cc_byte2,
  output logic [1:0]           buf_free
);

  localparam int N_FLD = 2;

  cc_mode_e   mode_eff;
  logic [1:0] hit;
  cc_pair_t   wr_pair;
  cc_pair_t   store [N_FLD];
  logic [N_FLD-1:0] full;

  cc_mode_sync i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .field_odd(field_odd),
    .mode_req (cc_mode_e'(cc_mode)),
    .mode_eff (mode_eff)
  );

  cc_line_match #(
    .LINE_W   (LINE_W),
    .ODD_LINE (ODD_LINE),
    .EVEN_LINE(EVEN_LINE)
  ) i_match (
    .line_stb (line_stb),
    .line_num (line_num),
    .field_odd(field_odd),
    .std_525  (std_525),
    .mode_eff (mode_eff),
    .hit      (hit)
  );

  assign wr_pair.b1 = wr_byte1;
  assign wr_pair.b2 = wr_byte2;

  // index 1 odd store, index 0 even store
  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    localparam logic FSEL = 1'(g);
    cc_field_buf i_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_en && (wr_fld == FSEL)),
      .wr_pair(wr_pair),
      .take   (hit[g]),
      .pair_q (store[g]),
      .full_q (full[g])
    );
    assign buf_free[g] = !full[g];
  end

  // output stage: line-long enable and captured pair
  logic     ins_q, ins_d;
  cc_pair_t out_q, out_d;
  logic     any_hit;
  logic     sel;

  assign any_hit = |hit;
  assign sel     = hit[1];

  always_comb begin
    ins_d = ins_q;
    out_d = out_q;
    if (line_stb) ins_d = any_hit;
    if (any_hit) out_d = full[sel] ? store[sel] : cc_null_pair();
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= 1'b0;
      out_q <= cc_null_pair();
    end else begin
      ins_q <= ins_d;
      if (any_hit) out_q <= out_d;
    end
  end

  assign ins_en   = ins_q;
  assign cc_byte1 = out_q.b1;
  assign cc_byte2 = out_q.b2;

endmodule

// File: rtl/cc_line_inserter_chk.sv
module cc_line_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       std_525,
  input logic       line_stb,
  input logic       wr_en,
  input logic       wr_fld,
  input logic       ins_en,
  input logic [1:0] buf_free
);

  // R2
  ins_only_at_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(ins_en));

  // R5
  no_ins_off_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !std_525) |=> !ins_en);

  // R6
  wr_odd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fld) |=> !buf_free[1]);

  // R6
  wr_even_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_fld) |=> !buf_free[0]);

  // R7
  odd_free_on_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_free[1]) |-> ins_en);

  // R7
  even_free_on_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_free[0]) |-> ins_en);

endmodule

bind cc_line_inserter cc_line_inserter_chk i_chk (.*);

// File: tb/test_cc_line_inserter.sv
module test_cc_line_inserter;

  logic       clk;
  logic       rst_n;
  logic       std_525;
  logic [1:0] cc_mode;
  logic       line_stb;
  logic [9:0] line_num;
  logic       field_odd;
  logic       wr_en;
  logic       wr_fld;
  logic [7:0] wr_byte1, wr_byte2;
  logic       ins_en;
  logic [7:0] cc_byte1, cc_byte2;
  logic [1:0] buf_free;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cc_line_inserter i_cc_line_inserter (
    .clk(clk), .rst_n(rst_n), .std_525(std_525), .cc_mode(cc_mode),
    .line_stb(line_stb), .line_num(line_num), .field_odd(field_odd),
    .wr_en(wr_en), .wr_fld(wr_fld), .wr_byte1(wr_byte1), .wr_byte2(wr_byte2),
    .ins_en(ins_en), .cc_byte1(cc_byte1), .cc_byte2(cc_byte2),
    .buf_free(buf_free)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic line(input int n, input bit odd);
    @(negedge clk);
    line_stb  = 1'b1;
    line_num  = 10'(n);
    field_odd = odd;
    @(negedge clk);
    line_stb  = 1'b0;
  endtask

  task automatic host_wr(input bit fld, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_fld = fld; wr_byte1 = a; wr_byte2 = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_ins(input string req, input logic [7:0] a, input logic [7:0] b);
    chk(req, "ins_en", int'(ins_en), 1);
    chk(req, "cc_byte1", int'(cc_byte1), int'(a));
    chk(req, "cc_byte2", int'(cc_byte2), int'(b));
  endtask

  task automatic t_reset();
    chk("R1", "ins_en", int'(ins_en), 0);
    chk("R1", "buf_free", int'(buf_free), 3);
    chk("R1", "cc_byte1", int'(cc_byte1), 'h80);
    chk("R1", "cc_byte2", int'(cc_byte2), 'h80);
  endtask

  task automatic t_odd_basic();
    cc_mode = 2'b01;
    line(1, 1'b1);
    chk("R2", "ins_en field start", int'(ins_en), 0);
    host_wr(1'b1, 8'h12, 8'h34);
    chk("R6", "buf_free odd after write", int'(buf_free), 2'b01);
    line(20, 1'b1);
    chk("R11", "ins_en line 20", int'(ins_en), 0);
    line(21, 1'b1);
    expect_ins("R2", 8'h12, 8'h34);
    chk("R7", "buf_free after insert", int'(buf_free), 3);
    repeat (3) @(negedge clk);
    chk("R2", "ins_en held", int'(ins_en), 1);
    line(22, 1'b1);
    chk("R2", "ins_en next line", int'(ins_en), 0);
  endtask

  task automatic t_mode_delay();
    cc_mode = 2'b00;
    line(21, 1'b1);
    expect_ins("R4", 8'h80, 8'h80);
    chk("R8", "null byte1", int'(cc_byte1), 'h80);
    line(22, 1'b1);
    chk("R4", "ins_en after", int'(ins_en), 0);
  endtask

  task automatic t_even_disabled();
    host_wr(1'b0, 8'h41, 8'h42);
    chk("R6", "buf_free even after write", int'(buf_free), 2'b10);
    line(264, 1'b0);
    line(284, 1'b0);
    chk("R3", "mode 00 even no ins", int'(ins_en), 0);
    chk("R10", "even store kept", int'(buf_free), 2'b10);
  endtask

  task automatic t_even_only();
    cc_mode = 2'b10;
    line(1, 1'b1);
    host_wr(1'b1, 8'h55, 8'h66);
    line(21, 1'b1);
    chk("R3", "mode 10 odd no ins", int'(ins_en), 0);
    chk("R3", "odd store kept", int'(buf_free), 2'b00);
    line(264, 1'b0);
    line(21, 1'b0);
    chk("R11", "line 21 even field", int'(ins_en), 0);
    line(284, 1'b0);
    expect_ins("R10", 8'h41, 8'h42);
    chk("R7", "even free", int'(buf_free), 2'b01);
    line(285, 1'b0);
    chk("R2", "ins_en after 284", int'(ins_en), 0);
  endtask

  task automatic t_non525();
    cc_mode = 2'b11;
    std_525 = 1'b0;
    line(1, 1'b1);
    line(21, 1'b1);
    chk("R5", "no ins off std", int'(ins_en), 0);
    chk("R5", "store kept off std", int'(buf_free), 2'b01);
    std_525 = 1'b1;
    line(264, 1'b0);
    line(284, 1'b0);
    expect_ins("R8", 8'h80, 8'h80);
    line(285, 1'b0);
    line(1, 1'b1);
    line(284, 1'b1);
    chk("R11", "line 284 odd field", int'(ins_en), 0);
    line(21, 1'b1);
    expect_ins("R3", 8'h55, 8'h66);
    chk("R7", "odd free", int'(buf_free), 3);
    line(22, 1'b1);
  endtask

  task automatic t_collision();
    host_wr(1'b1, 8'h11, 8'h22);
    line(264, 1'b0);
    line(265, 1'b0);
    line(1, 1'b1);
    @(negedge clk);
    line_stb = 1'b1; line_num = 10'd21; field_odd = 1'b1;
    wr_en = 1'b1; wr_fld = 1'b1; wr_byte1 = 8'h33; wr_byte2 = 8'h44;
    @(negedge clk);
    line_stb = 1'b0; wr_en = 1'b0;
    expect_ins("R9", 8'h11, 8'h22);
    chk("R9", "odd stays busy", int'(buf_free), 2'b01);
    line(22, 1'b1);
    line(264, 1'b0);
    line(265, 1'b0);
    line(1, 1'b1);
    line(21, 1'b1);
    expect_ins("R9", 8'h33, 8'h44);
    chk("R7", "odd free after second", int'(buf_free), 3);
    line(22, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; std_525 = 1'b1; cc_mode = 2'b00; line_stb = 1'b0;
    line_num = '0; field_odd = 1'b0; wr_en = 1'b0; wr_fld = 1'b0;
    wr_byte1 = '0; wr_byte2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_odd_basic();
    t_mode_delay();
    t_even_disabled();
    t_even_only();
    t_non525();
    t_collision();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule